// File: doc/BRIEF.md
# DRAM Upper-Address Multiplexer with Refresh Conversion

This block lets a host memory controller that only produces the low eight multiplexed DRAM address lines reach a 1 MB DRAM module. The block drives the four upper address lines from a CPU-writable page register. It chooses between the row nibble and the column nibble from the levels of the host RAS and CAS strobes, after they have been synchronised to the block clock. No separate select strobe is used. The DRAM needs no address setup time but does need hold time, so changing the upper lines at the strobe edges is safe. When neither strobe is active, the upper lines are released: the output enable goes low and a pad driver outside the block tri-states them.

Paging applies only to accesses in the lower half of the CPU map. The most significant CPU address bit is sampled when a normal access leaves `ST_IDLE`. If it is set, zeros are driven in both the row and the column phase. Refresh is handled by conversion. A RAS falling edge that arrives while E and the active-low horizontal sync are both low opens a refresh. For that refresh, the DRAM CAS output follows the host RAS, and the DRAM RAS output is built from the Q clock. The DRAM therefore sees CAS fall before RAS.

The strobe state machine has these states and transitions:
- `ST_IDLE`: both strobes inactive. From here:
  - host RAS low inside the refresh window → `ST_RF_CAS`;
  - otherwise the level decode picks `ST_ROW` (RAS only), `ST_COL` (both low) or `ST_CTAIL` (CAS only).
- `ST_ROW`, `ST_COL`, `ST_CTAIL`: follow the same level decode on every cycle, and return to `ST_IDLE` when both strobes are high.
- `ST_RF_CAS`: moves to `ST_RF_BOTH` once Q is high, or to `ST_IDLE` when host RAS rises.
- `ST_RF_BOTH`: stays until host RAS rises, then returns to `ST_IDLE`.

Top module: `dram_hiaddr_mux`

## Requirements
- R1: While reset is held and after its release, the outputs are `dram_ras_n`=1, `dram_cas_n`=1, `dram_hi_oe`=0 and `dram_hi_addr`=0. The page register resets to 0x00.
- R2: With host RAS and CAS both high, the upper lines are released (`dram_hi_oe`=0, `dram_hi_addr`=0) and both DRAM strobes are high.
- R3: With host RAS low and CAS high outside a refresh, `dram_ras_n`=0, `dram_cas_n`=1, `dram_hi_oe`=1, and `dram_hi_addr` carries page bits [3:0]. The value holds steady for the whole row phase.
- R4: With host CAS low outside a refresh, `dram_cas_n`=0, `dram_hi_oe`=1, and `dram_hi_addr` carries page bits [7:4]. This holds whether host RAS is low (`dram_ras_n`=0) or already high (`dram_ras_n`=1).
- R5: `cpu_addr[15]` is sampled when a normal access leaves the idle state. If it is 1, `dram_hi_addr` is 0 in both the row and the column phase of that access.
- R6: The page register loads `cpu_data` only on a falling edge of `e_clk` with `cpu_rw`=0 and `cpu_addr`=0xFF30. A write to another address, or with `cpu_rw`=1, leaves the page unchanged.
- R7: When host RAS falls while `e_clk`=0 and `hsync_n`=0, the outputs first show `dram_cas_n`=0, `dram_ras_n`=1. They change to both low only once `q_clk` is high, and never in the same cycle the refresh starts, so CAS always falls first. `dram_hi_oe` stays 0 throughout.
- R8: The refresh decision is made only at the host RAS falling edge. A window that opens during a normal access does not turn that access into a refresh. A refresh that has started continues until host RAS rises, even if the window closes or Q falls.
- R9: Every output reacts to a strobe or clock input change exactly SYNC_STAGES+1 (default 3) rising clock edges after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ras_n | input | 1 | Host controller RAS strobe, active low |
| host_cas_n | input | 1 | Host controller CAS strobe, active low |
| e_clk | input | 1 | CPU E clock |
| q_clk | input | 1 | CPU Q clock |
| hsync_n | input | 1 | Horizontal sync, active low |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | CPU read/write, 0 = write |
| dram_ras_n | output | 1 | RAS strobe to the DRAM |
| dram_cas_n | output | 1 | CAS strobe to the DRAM |
| dram_hi_addr | output | 4 | Upper DRAM address nibble |
| dram_hi_oe | output | 1 | Drive enable for the upper address pads |

## Verification
A strobe or clock input change passes through two synchroniser flops and then the state register. Its effect on any output is therefore due at the third rising edge, and is read at the falling edge that follows. The driver records each expected output tuple with the absolute cycle in which it is due. For the first RAS fall it also records the unchanged tuple one cycle earlier, which pins the latency exactly. When a refresh opens with Q already high, the driver records two tuples: the CAS-only tuple at the due cycle and the both-low tuple one cycle later, so the CAS-first order is checked cycle by cycle. Page writes are judged later, through the row and column nibbles of the next access.

// File: rtl/dram_hiaddr_pkg.sv
package dram_hiaddr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CTAIL,
        ST_RF_CAS,
        ST_RF_BOTH
    } strobe_st_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic e;
        logic q;
        logic hs_n;
    } ctl_s;

    localparam int CTL_W = $bits(ctl_s);
    localparam logic [CTL_W-1:0] CTL_RST = 5'b11101;

endpackage

// File: rtl/dram_sync.sv
module dram_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/dram_page_reg.sv
module dram_page_reg #(
    parameter int              AW        = 16,
    parameter int              DW        = 8,
    parameter logic [AW-1:0]   PAGE_ADDR = 16'hFF30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          e_s,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_data,
    input  logic          cpu_rw,
    output logic [DW-1:0] page,
    output logic          wr_stb
);

    logic e_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_prev <= 1'b1;
        else        e_prev <= e_s;
    end

    assign wr_stb = e_prev && !e_s && !cpu_rw && (cpu_addr == PAGE_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      page <= '0;
        else if (wr_stb) page <= cpu_data;
    end

endmodule

// File: rtl/dram_strobe_fsm.sv
module dram_strobe_fsm
    import dram_hiaddr_pkg::*;
#(
    parameter int UPPER_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ras_s,
    input  logic               cas_s,
    input  logic               e_s,
    input  logic               q_s,
    input  logic               hs_s,
    input  logic               upper_half,
    input  logic [UPPER_W-1:0] page_row,
    input  logic [UPPER_W-1:0] page_col,
    output logic               ras_o,
    output logic               cas_o,
    output logic [UPPER_W-1:0] hi_addr,
    output logic               hi_oe,
    output strobe_st_e         st
);

    strobe_st_e nxt;
    logic       hit;
    logic       win;

    assign win = !e_s && !hs_s;

    function automatic strobe_st_e level_decode(input logic r, input logic c);
        if (!c) return r ? ST_CTAIL : ST_COL;
        return r ? ST_IDLE : ST_ROW;
    endfunction

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (!ras_s && win) nxt = ST_RF_CAS;
                else               nxt = level_decode(ras_s, cas_s);
            end
            ST_ROW, ST_COL, ST_CTAIL: nxt = level_decode(ras_s, cas_s);
            ST_RF_CAS: begin
                if (ras_s)     nxt = ST_IDLE;
                else if (q_s)  nxt = ST_RF_BOTH;
                else           nxt = ST_RF_CAS;
            end
            ST_RF_BOTH: nxt = ras_s ? ST_IDLE : ST_RF_BOTH;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            hit <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && (nxt == ST_ROW || nxt == ST_COL || nxt == ST_CTAIL))
                hit <= !upper_half;
        end
    end

    logic [UPPER_W-1:0] row_v, col_v;
    assign row_v = hit ? page_row : '0;
    assign col_v = hit ? page_col : '0;

    always_comb begin
        ras_o   = 1'b1;
        cas_o   = 1'b1;
        hi_oe   = 1'b0;
        hi_addr = '0;
        unique case (st)
            ST_IDLE: ;
            ST_ROW: begin
                ras_o = 1'b0; hi_oe = 1'b1; hi_addr = row_v;
            end
            ST_COL: begin
                ras_o = 1'b0; cas_o = 1'b0; hi_oe = 1'b1; hi_addr = col_v;
            end
            ST_CTAIL: begin
                cas_o = 1'b0; hi_oe = 1'b1; hi_addr = col_v;
            end
            ST_RF_CAS:  cas_o = 1'b0;
            ST_RF_BOTH: begin
                ras_o = 1'b0; cas_o = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dram_hiaddr_mux.sv
module dram_hiaddr_mux
    import dram_hiaddr_pkg::*;
#(
    parameter int                 UPPER_W     = 4,
    parameter int                 CPU_AW      = 16,
    parameter int                 CPU_DW      = 8,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [CPU_AW-1:0]  PAGE_ADDR   = 16'hFF30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_ras_n,
    input  logic               host_cas_n,
    input  logic               e_clk,
    input  logic               q_clk,
    input  logic               hsync_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [CPU_DW-1:0]  cpu_data,
    input  logic               cpu_rw,
    output logic               dram_ras_n,
    output logic               dram_cas_n,
    output logic [UPPER_W-1:0] dram_hi_addr,
    output logic               dram_hi_oe
);

    localparam int PAGE_W = 2 * UPPER_W;

    ctl_s              ctl_raw, ctl_s_q;
    logic [PAGE_W-1:0] page;
    logic              page_wr;
    strobe_st_e        st;

    assign ctl_raw = '{ras_n: host_ras_n, cas_n: host_cas_n,
                       e: e_clk, q: q_clk, hs_n: hsync_n};

    dram_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST(CTL_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s_q)
    );

    dram_page_reg #(.AW(CPU_AW), .DW(PAGE_W), .PAGE_ADDR(PAGE_ADDR)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .e_s      (ctl_s_q.e),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data[PAGE_W-1:0]),
        .cpu_rw   (cpu_rw),
        .page     (page),
        .wr_stb   (page_wr)
    );

    dram_strobe_fsm #(.UPPER_W(UPPER_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_s      (ctl_s_q.ras_n),
        .cas_s      (ctl_s_q.cas_n),
        .e_s        (ctl_s_q.e),
        .q_s        (ctl_s_q.q),
        .hs_s       (ctl_s_q.hs_n),
        .upper_half (cpu_addr[CPU_AW-1]),
        .page_row   (page[UPPER_W-1:0]),
        .page_col   (page[PAGE_W-1:UPPER_W]),
        .ras_o      (dram_ras_n),
        .cas_o      (dram_cas_n),
        .hi_addr    (dram_hi_addr),
        .hi_oe      (dram_hi_oe),
        .st         (st)
    );

endmodule

// File: rtl/dram_hiaddr_chk.sv
module dram_hiaddr_chk
    import dram_hiaddr_pkg::*;
#(
    parameter int UPPER_W = 4,
    parameter int PAGE_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dram_ras_n,
    input logic               dram_cas_n,
    input logic               dram_hi_oe,
    input logic [UPPER_W-1:0] dram_hi_addr,
    input strobe_st_e         st,
    input logic [PAGE_W-1:0]  page,
    input logic               page_wr
);

    a_r2_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n && dram_cas_n) |-> (!dram_hi_oe && dram_hi_addr == '0));

    a_r3_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ROW && $past(st) == ST_ROW) |-> $stable(dram_hi_addr));

    a_r6_page_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(page_wr) |-> $stable(page));

    a_r7_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RF_BOTH && $past(st) != ST_RF_BOTH) |-> ($past(!dram_cas_n) && $past(dram_ras_n)));

    a_r7_refresh_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RF_CAS || st == ST_RF_BOTH) |-> !dram_hi_oe);

    a_r8_refresh_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_RF_BOTH && st != ST_RF_BOTH) |-> st == ST_IDLE);

endmodule

bind dram_hiaddr_mux dram_hiaddr_chk #(.UPPER_W(UPPER_W), .PAGE_W(2 * UPPER_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dram_ras_n   (dram_ras_n),
    .dram_cas_n   (dram_cas_n),
    .dram_hi_oe   (dram_hi_oe),
    .dram_hi_addr (dram_hi_addr),
    .st           (st),
    .page         (page),
    .page_wr      (page_wr)
);

// File: tb/sim_dram_hiaddr_mux.sv
`timescale 1ns/1ps
module sim_dram_hiaddr_mux;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_ras_n = 1'b1, host_cas_n = 1'b1;
    logic        e_clk = 1'b1, q_clk = 1'b0, hsync_n = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_rw = 1'b1;
    logic        dram_ras_n, dram_cas_n, dram_hi_oe;
    logic [3:0]  dram_hi_addr;

    always #5 clk = ~clk;

    dram_hiaddr_mux u0 (
        .clk(clk), .rst_n(rst_n), .host_ras_n(host_ras_n), .host_cas_n(host_cas_n),
        .e_clk(e_clk), .q_clk(q_clk), .hsync_n(hsync_n), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .cpu_rw(cpu_rw), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_hi_addr(dram_hi_addr), .dram_hi_oe(dram_hi_oe)
    );

    typedef struct {
        int         due;
        logic [6:0] exp;
        string      tag;
    } item_t;

    item_t q_exp[$];
    int    cyc = 0;
    int    n_chk = 0, n_fail = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got ras=%b cas=%b oe=%b addr=%h, expected ras=%b cas=%b oe=%b addr=%h",
                     tag, act[6], act[5], act[4], act[3:0], exp[6], exp[5], exp[4], exp[3:0]);
        end
    endtask

    // monitor: pops expected items when due
    initial begin
        forever begin
            @(negedge clk);
            while (q_exp.size() > 0 && q_exp[0].due <= cyc) begin
                check(q_exp[0].tag, {dram_ras_n, dram_cas_n, dram_hi_oe, dram_hi_addr}, q_exp[0].exp);
                void'(q_exp.pop_front());
            end
        end
    end

    task automatic expect_at(int ofs, logic r, logic c, logic oe, logic [3:0] a, string tag);
        item_t it;
        it.due = cyc + ofs;
        it.exp = {r, c, oe, a};
        it.tag = tag;
        q_exp.push_back(it);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobes(logic r, logic c);
        @(negedge clk);
        host_ras_n = r;
        host_cas_n = c;
    endtask

    task automatic ctl(logic e, logic q, logic h);
        @(negedge clk);
        e_clk = e;
        q_clk = q;
        hsync_n = h;
    endtask

    task automatic reg_write(logic [15:0] a, logic [7:0] d, logic rw);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = rw;
        wait_n(2);
        e_clk = 1'b0;
        wait_n(6);
        e_clk = 1'b1;
        wait_n(4);
        cpu_rw = 1'b1;
    endtask

    task automatic mem_cycle(logic [15:0] a, logic [3:0] row, logic [3:0] col, string tag);
        @(negedge clk);
        cpu_addr = a;
        strobes(1'b0, 1'b1);
        expect_at(LAT - 1, 1, 1, 0, 4'h0, "R9 still idle before due cycle");
        expect_at(LAT, 0, 1, 1, row, {tag, " R3 row phase"});
        wait_n(5);
        strobes(1'b0, 1'b0);
        expect_at(LAT, 0, 0, 1, col, {tag, " R4 column phase"});
        wait_n(5);
        strobes(1'b1, 1'b0);
        expect_at(LAT, 1, 0, 1, col, {tag, " R4 column after RAS high"});
        wait_n(5);
        strobes(1'b1, 1'b1);
        expect_at(LAT, 1, 1, 0, 4'h0, {tag, " R2 released"});
        wait_n(5);
    endtask

    initial begin
        wait_n(3);
        check("R1 outputs during reset", {dram_ras_n, dram_cas_n, dram_hi_oe, dram_hi_addr}, 7'b1100000);
        rst_n = 1'b1;
        wait_n(4);
        check("R1 outputs after reset", {dram_ras_n, dram_cas_n, dram_hi_oe, dram_hi_addr}, 7'b1100000);
        check("R2 idle released", {dram_ras_n, dram_cas_n, dram_hi_oe, dram_hi_addr}, 7'b1100000);

        mem_cycle(16'h1234, 4'h0, 4'h0, "R1 page zero");

        reg_write(16'hFF30, 8'hA5, 1'b0);
        mem_cycle(16'h1234, 4'h5, 4'hA, "R6 page A5");
        mem_cycle(16'h9000, 4'h0, 4'h0, "R5 upper half");

        reg_write(16'hFF31, 8'h3C, 1'b0);
        mem_cycle(16'h0100, 4'h5, 4'hA, "R6 wrong address ignored");
        reg_write(16'hFF30, 8'h3C, 1'b1);
        mem_cycle(16'h0100, 4'h5, 4'hA, "R6 read ignored");
        reg_write(16'hFF30, 8'h3C, 1'b0);
        mem_cycle(16'h7FFF, 4'hC, 4'h3, "R6 page 3C");

        // refresh with Q low at RAS fall
        ctl(1'b0, 1'b0, 1'b0);
        wait_n(4);
        strobes(1'b0, 1'b1);
        expect_at(LAT, 1, 0, 0, 4'h0, "R7 CAS only first");
        wait_n(5);
        ctl(1'b0, 1'b1, 1'b0);
        expect_at(LAT, 0, 0, 0, 4'h0, "R7 RAS from Q");
        wait_n(5);
        ctl(1'b0, 1'b0, 1'b0);
        expect_at(LAT, 0, 0, 0, 4'h0, "R8 held after Q falls");
        wait_n(5);
        strobes(1'b1, 1'b1);
        expect_at(LAT, 1, 1, 0, 4'h0, "R7 refresh end");
        wait_n(5);

        // refresh with Q already high
        ctl(1'b0, 1'b1, 1'b0);
        wait_n(4);
        strobes(1'b0, 1'b1);
        expect_at(LAT, 1, 0, 0, 4'h0, "R7 CAS first with Q high");
        expect_at(LAT + 1, 0, 0, 0, 4'h0, "R7 RAS one cycle later");
        wait_n(5);
        strobes(1'b1, 1'b1);
        expect_at(LAT, 1, 1, 0, 4'h0, "R7 refresh end");
        wait_n(5);
        ctl(1'b1, 1'b0, 1'b1);
        wait_n(4);

        // window opens mid-access
        @(negedge clk);
        cpu_addr = 16'h1234;
        strobes(1'b0, 1'b1);
        expect_at(LAT, 0, 1, 1, 4'hC, "R8 normal row");
        wait_n(5);
        ctl(1'b0, 1'b0, 1'b0);
        expect_at(LAT, 0, 1, 1, 4'hC, "R8 row kept in window");
        wait_n(5);
        strobes(1'b0, 1'b0);
        expect_at(LAT, 0, 0, 1, 4'h3, "R8 column kept in window");
        wait_n(5);
        strobes(1'b1, 1'b1);
        expect_at(LAT, 1, 1, 0, 4'h0, "R2 released");
        wait_n(5);
        strobes(1'b0, 1'b1);
        expect_at(LAT, 1, 0, 0, 4'h0, "R7 refresh start");
        wait_n(5);
        ctl(1'b1, 1'b0, 1'b1);
        expect_at(LAT, 1, 0, 0, 4'h0, "R8 refresh kept after window closes");
        wait_n(5);
        ctl(1'b1, 1'b1, 1'b1);
        expect_at(LAT, 0, 0, 0, 4'h0, "R8 RAS from Q after window");
        wait_n(5);
        strobes(1'b1, 1'b1);
        expect_at(LAT, 1, 1, 0, 4'h0, "R8 refresh end");
        wait_n(5);
        ctl(1'b1, 1'b0, 1'b1);

        wait_n(10);
        while (q_exp.size() > 0) wait_n(1);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule